// File: doc/BRIEF.md
# Synthesizer Frequency Register Bank

This block keeps the 20-bit divider control word for an integer-N frequency synthesizer. Three word sources live inside it: a primary register written bit by bit from a clock/data serial port, a secondary register that takes a full copy of the primary on a strobe, and a store-backed register. The store-backed register is filled in parallel from a nonvolatile store's read port. It can also be shifted serially, either to build a word for the store's write port or to read its contents out one bit at a time. A set of select inputs chooses which source drives the divider control outputs. The chosen word is also split into the reference (R), main (M) and swallow (A) counter fields and a prescaler-bypass bit.

All inputs are sampled on the system clock. Edges of the serial clock, the copy strobe and the two store-control inputs are found by comparing each input with its value from the previous cycle, so every register update is synchronous to `clk`.

While the store-backed register is selected, it only ever presents words that came from the store. After any serial shift into it, the output stays at the last store-sourced word until the next parallel load from the store.

Top module: `freq_word_bank`

## Requirements
- R1: After reset, all three registers are zero. `word_out`, every decoded field, `store_wdata` and `ser_dout` are zero.
- R2: A shift takes place on a cycle where `ser_clk` is high after being low in the previous cycle. When `ser_en` is also high and `ser_addr` = 2'b01, the primary register shifts: `ser_data` enters B19 and every bit moves one place toward B0. After 20 shifts, the first bit sent sits in B0.
- R3: With `ee_sel`=0, `freq_sel`=1 and `ee_load`=0, `word_out` shows the primary register live, including every intermediate value while it is being shifted.
- R4: A rising edge of `copy_strobe` copies the whole primary register into the secondary register. With `ee_sel`=0, `freq_sel`=0 and `ee_load`=0, `word_out` shows the secondary register. Later shifts of the primary do not change it.
- R5: A rising edge of `ee_sel` while `ee_load`=0 copies `store_rdata` into the store-backed register. A rising edge of `ee_sel` while `ee_load`=1 loads nothing.
- R6: A falling edge of `ee_load` while `ee_sel`=1 copies `store_rdata` into the store-backed register.
- R7: With `ser_en`=1 and `ser_addr` = 2'b10, a serial shift goes into the store-backed register, and `store_wdata` always shows its contents. While `ee_sel`=1 and `ee_load`=0, `word_out` keeps the last word loaded from the store until the next store load.
- R8: With `readout_en`=1, `ser_dout` equals B0 of the store-backed register. Each serial clock edge shifts that register toward B0 and fills B19 from `ser_data`, whatever the values of `ser_en` and `ser_addr`.
- R9: With `readout_en`=0, `ser_dout` is 0.
- R10: The fields are decoded from `word_out` as follows. `r_div`[5:4] = B0,B1 and `r_div`[3:0] = B12..B15. `m_div`[8:7] = B2,B3 and `m_div`[6:0] = B5..B11. `a_div`[3:0] = B16..B19. In every field the lower bit number goes to the more significant field bit. `pscl_bypass` = B4.
- R11: While `ee_load`=1, `word_out` holds the value it had in the cycle before.
- R12: The primary register does not change when `ser_en`=0, when `ser_addr` is 2'b00 or 2'b11, or while `ser_clk` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ser_clk | input | 1 | Serial port clock, sampled on `clk` |
| ser_data | input | 1 | Serial port data |
| ser_en | input | 1 | Serial load enable |
| ser_addr | input | 2 | Shift target: 01 primary, 10 store-backed, other values none |
| copy_strobe | input | 1 | Rising edge copies primary into secondary |
| ee_sel | input | 1 | Selects the store-backed register; rising edge loads it from the store |
| ee_load | input | 1 | Freezes the output while high; falling edge loads from the store |
| freq_sel | input | 1 | 1 selects primary, 0 selects secondary, when `ee_sel`=0 |
| readout_en | input | 1 | Enables serial readout of the store-backed register |
| store_rdata | input | 20 | Parallel word from the nonvolatile store |
| store_wdata | output | 20 | Store-backed register contents, the store's write word |
| ser_dout | output | 1 | Serial readout bit |
| word_out | output | 20 | Selected divider control word |
| r_div | output | 6 | Reference counter field |
| m_div | output | 9 | Main counter field |
| a_div | output | 4 | Swallow counter field |
| pscl_bypass | output | 1 | Prescaler bypass bit |

## Verification
The hardest state to reach is a store-backed register that has been serially overwritten while it is selected. In that state the output must keep the last store word even though `store_wdata` shows the new contents. The stimulus gets there by loading a store word through a rising `ee_sel`, then shifting a different 20-bit word in through address 10 with `ee_sel` still high. Both outputs are then compared. A second case is also checked: a rising `ee_sel` that arrives while `ee_load` is high. Here the output is frozen, so the missing load shows up only on `store_wdata`, and only a later falling `ee_load` brings in the new store word.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
    localparam int WORD_W  = 20;
    localparam int R_W     = 6;
    localparam int M_W     = 9;
    localparam int A_W     = 4;
    localparam int N_EDGE  = 4;

    // Bit positions that the counter decode depends on
    localparam int R_HI_LSB  = 0;   // two bits feeding r[5:4]
    localparam int M_HI_LSB  = 2;   // two bits feeding m[8:7]
    localparam int PB_POS    = 4;
    localparam int M_LO_LSB  = 5;   // seven bits feeding m[6:0]
    localparam int R_LO_LSB  = 12;  // four bits feeding r[3:0]
    localparam int A_LSB     = 16;  // four bits feeding a[3:0]

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_PRI  = 2'b01,
        TGT_EE   = 2'b10,
        TGT_RSV  = 2'b11
    } shift_tgt_e;

    typedef enum logic [1:0] {
        SRC_PRI,
        SRC_SEC,
        SRC_EE,
        SRC_HOLD
    } word_src_e;

    typedef struct packed {
        logic [WORD_W-1:0] pri;
        logic [WORD_W-1:0] sec;
        logic [WORD_W-1:0] ee;
        logic [WORD_W-1:0] shadow;
        logic [WORD_W-1:0] held;
        logic              ee_dirty;
    } bank_t;
endpackage

// File: rtl/fwb_edge_det.sv
module fwb_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] =  sig[i] & ~prev_q[i];
        assign fall[i] = ~sig[i] &  prev_q[i];
    end
endmodule

// File: rtl/fwb_field_map.sv
module fwb_field_map
    import fwb_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [R_W-1:0]    r_fld,
    output logic [M_W-1:0]    m_fld,
    output logic [A_W-1:0]    a_fld,
    output logic              pb
);
    // Lower word bit feeds the more significant field bit in every group
    for (genvar k = 0; k < 2; k++) begin : g_r_hi
        assign r_fld[R_W-1-k] = word[R_HI_LSB+k];
    end
    for (genvar k = 0; k < R_W-2; k++) begin : g_r_lo
        assign r_fld[R_W-3-k] = word[R_LO_LSB+k];
    end
    for (genvar k = 0; k < 2; k++) begin : g_m_hi
        assign m_fld[M_W-1-k] = word[M_HI_LSB+k];
    end
    for (genvar k = 0; k < M_W-2; k++) begin : g_m_lo
        assign m_fld[M_W-3-k] = word[M_LO_LSB+k];
    end
    for (genvar k = 0; k < A_W; k++) begin : g_a
        assign a_fld[A_W-1-k] = word[A_LSB+k];
    end
    assign pb = word[PB_POS];
endmodule

// File: rtl/fwb_src_mux.sv
module fwb_src_mux
    import fwb_pkg::*;
(
    input  word_src_e         src,
    input  logic [WORD_W-1:0] pri,
    input  logic [WORD_W-1:0] sec,
    input  logic [WORD_W-1:0] ee,
    input  logic [WORD_W-1:0] shadow,
    input  logic              ee_dirty,
    input  logic [WORD_W-1:0] held,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        unique case (src)
            SRC_PRI:  word = pri;
            SRC_SEC:  word = sec;
            SRC_EE:   word = ee_dirty ? shadow : ee;
            default:  word = held;
        endcase
    end
endmodule

// File: rtl/freq_word_bank.sv
module freq_word_bank
    import fwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_en,
    input  logic [1:0]        ser_addr,
    input  logic              copy_strobe,
    input  logic              ee_sel,
    input  logic              ee_load,
    input  logic              freq_sel,
    input  logic              readout_en,
    input  logic [WORD_W-1:0] store_rdata,
    output logic [WORD_W-1:0] store_wdata,
    output logic              ser_dout,
    output logic [WORD_W-1:0] word_out,
    output logic [R_W-1:0]    r_div,
    output logic [M_W-1:0]    m_div,
    output logic [A_W-1:0]    a_div,
    output logic              pscl_bypass
);
    localparam int E_SCLK = 0;
    localparam int E_COPY = 1;
    localparam int E_SEL  = 2;
    localparam int E_LOAD = 3;

    bank_t             st_d, st_q;
    logic [N_EDGE-1:0] edge_in, rise, fall;
    word_src_e         src;
    shift_tgt_e        tgt;
    logic              sclk_rise, store_copy, pri_shift, ee_shift;
    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] pri_word, sec_word, ee_word;

    assign edge_in = {ee_load, ee_sel, copy_strobe, ser_clk};

    fwb_edge_det #(.N(N_EDGE)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (edge_in),
        .rise  (rise),
        .fall  (fall)
    );

    always_comb begin
        tgt        = shift_tgt_e'(ser_addr);
        sclk_rise  = rise[E_SCLK];
        pri_shift  = sclk_rise && ser_en && (tgt == TGT_PRI);
        ee_shift   = sclk_rise && ((ser_en && (tgt == TGT_EE)) || readout_en);
        store_copy = (rise[E_SEL] && !ee_load) || (fall[E_LOAD] && ee_sel);

        if (ee_load)       src = SRC_HOLD;
        else if (ee_sel)   src = SRC_EE;
        else if (freq_sel) src = SRC_PRI;
        else               src = SRC_SEC;
    end

    fwb_src_mux u_mux (
        .src      (src),
        .pri      (st_q.pri),
        .sec      (st_q.sec),
        .ee       (st_q.ee),
        .shadow   (st_q.shadow),
        .ee_dirty (st_q.ee_dirty),
        .held     (st_q.held),
        .word     (sel_word)
    );

    always_comb begin
        st_d = st_q;
        if (pri_shift)
            st_d.pri = {ser_data, st_q.pri[WORD_W-1:1]};
        if (rise[E_COPY])
            st_d.sec = st_q.pri;
        if (store_copy) begin
            st_d.ee       = store_rdata;
            st_d.shadow   = store_rdata;
            st_d.ee_dirty = 1'b0;
        end else if (ee_shift) begin
            st_d.ee       = {ser_data, st_q.ee[WORD_W-1:1]};
            st_d.ee_dirty = 1'b1;
        end
        st_d.held = sel_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pri_word    = st_q.pri;
    assign sec_word    = st_q.sec;
    assign ee_word     = st_q.ee;
    assign word_out    = sel_word;
    assign store_wdata = st_q.ee;
    assign ser_dout    = readout_en ? st_q.ee[0] : 1'b0;

    fwb_field_map u_fields (
        .word  (sel_word),
        .r_fld (r_div),
        .m_fld (m_div),
        .a_fld (a_div),
        .pb    (pscl_bypass)
    );
endmodule

// File: rtl/fwb_checker.sv
module fwb_checker
    import fwb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ser_clk,
    input logic              ser_en,
    input logic [1:0]        ser_addr,
    input logic              copy_strobe,
    input logic              ee_sel,
    input logic              ee_load,
    input logic              readout_en,
    input logic [WORD_W-1:0] store_rdata,
    input logic [WORD_W-1:0] pri_word,
    input logic [WORD_W-1:0] sec_word,
    input logic [WORD_W-1:0] ee_word,
    input logic [WORD_W-1:0] word_out,
    input logic              ser_dout
);
    // R9
    dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !readout_en |-> ser_dout == 1'b0);

    // R8
    dout_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        readout_en |-> ser_dout == ee_word[0]);

    // R4
    sec_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy_strobe) |=> sec_word == $past(pri_word));

    // R5
    ee_sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ee_sel) && !ee_load) |=> ee_word == $past(store_rdata));

    // R6
    ee_fall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ee_load) && ee_sel) |=> ee_word == $past(store_rdata));

    // R11
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_load |-> word_out == $past(word_out));

    // R12
    pri_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pri_word) |-> $past(ser_en && ser_clk && ser_addr == 2'b01));
endmodule

bind freq_word_bank fwb_checker u_fwb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk     (ser_clk),
    .ser_en      (ser_en),
    .ser_addr    (ser_addr),
    .copy_strobe (copy_strobe),
    .ee_sel      (ee_sel),
    .ee_load     (ee_load),
    .readout_en  (readout_en),
    .store_rdata (store_rdata),
    .pri_word    (pri_word),
    .sec_word    (sec_word),
    .ee_word     (ee_word),
    .word_out    (word_out),
    .ser_dout    (ser_dout)
);

// File: tb/tb_freq_word_bank.sv
`timescale 1ns/1ps
module tb_freq_word_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
    logic [1:0]  ser_addr = 2'b00;
    logic        copy_strobe = 1'b0, ee_sel = 1'b0, ee_load = 1'b0;
    logic        freq_sel = 1'b0, readout_en = 1'b0;
    logic [19:0] store_rdata = '0;
    logic [19:0] store_wdata, word_out;
    logic        ser_dout, pscl_bypass;
    logic [5:0]  r_div;
    logic [8:0]  m_div;
    logic [3:0]  a_div;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [19:0] exp_pri, exp_ee;

    localparam logic [19:0] W1 = 20'hA5C3E;
    localparam logic [19:0] W2 = 20'h3B71D;
    localparam logic [19:0] W3 = 20'h6E0F9;
    localparam logic [19:0] W4 = 20'h1248F;

    always #10 clk = ~clk;

    freq_word_bank dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .ser_addr(ser_addr), .copy_strobe(copy_strobe),
        .ee_sel(ee_sel), .ee_load(ee_load), .freq_sel(freq_sel),
        .readout_en(readout_en), .store_rdata(store_rdata),
        .store_wdata(store_wdata), .ser_dout(ser_dout), .word_out(word_out),
        .r_div(r_div), .m_div(m_div), .a_div(a_div), .pscl_bypass(pscl_bypass)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ser_bit(input logic b, input logic [1:0] addr, input logic en);
        ser_addr = addr; ser_en = en; ser_data = b; ser_clk = 1'b1;
        tick(2);
        ser_clk = 1'b0;
        tick(1);
        ser_en = 1'b0;
    endtask

    task automatic ser_word(input logic [19:0] w, input logic [1:0] addr);
        for (int i = 0; i < 20; i++) ser_bit(w[i], addr, 1'b1);
    endtask

    task automatic chk_fields(input string tag, input logic [19:0] w);
        logic [5:0] r; logic [8:0] m; logic [3:0] a;
        r = {w[0], w[1], w[12], w[13], w[14], w[15]};
        m = {w[2], w[3], w[5], w[6], w[7], w[8], w[9], w[10], w[11]};
        a = {w[16], w[17], w[18], w[19]};
        chk({tag, " r"}, 32'(r_div), 32'(r));
        chk({tag, " m"}, 32'(m_div), 32'(m));
        chk({tag, " a"}, 32'(a_div), 32'(a));
        chk({tag, " pb"}, 32'(pscl_bypass), 32'(w[4]));
    endtask

    task automatic t_reset();
        chk("R1 word_out", 32'(word_out), 0);
        chk("R1 store_wdata", 32'(store_wdata), 0);
        chk("R1 dout", 32'(ser_dout), 0);
        chk_fields("R1", 20'h0);
    endtask

    task automatic t_primary_load();
        freq_sel = 1'b1;
        ser_word(W1, 2'b01);
        exp_pri = W1;
        chk("R2 primary word", 32'(word_out), 32'(W1));
        chk_fields("R10 W1", W1);
    endtask

    task automatic t_live();
        ser_bit(1'b1, 2'b01, 1'b1);
        exp_pri = {1'b1, exp_pri[19:1]};
        chk("R3 live shift 1", 32'(word_out), 32'(exp_pri));
        ser_bit(1'b0, 2'b01, 1'b1);
        exp_pri = {1'b0, exp_pri[19:1]};
        chk("R3 live shift 2", 32'(word_out), 32'(exp_pri));
        chk_fields("R10 live", exp_pri);
    endtask

    task automatic t_no_shift();
        ser_bit(1'b1, 2'b00, 1'b1);
        chk("R12 addr 00", 32'(word_out), 32'(exp_pri));
        ser_bit(1'b1, 2'b11, 1'b1);
        chk("R12 addr 11", 32'(word_out), 32'(exp_pri));
        ser_bit(1'b1, 2'b01, 1'b0);
        chk("R12 enable low", 32'(word_out), 32'(exp_pri));
        ser_addr = 2'b01; ser_en = 1'b1; ser_data = 1'b1; ser_clk = 1'b1;
        tick(6);
        ser_clk = 1'b0; tick(1); ser_en = 1'b0;
        exp_pri = {1'b1, exp_pri[19:1]};
        chk("R12 held clock single shift", 32'(word_out), 32'(exp_pri));
    endtask

    task automatic t_secondary();
        logic [19:0] copied;
        copied = exp_pri;
        copy_strobe = 1'b1; tick(2); copy_strobe = 1'b0; tick(1);
        freq_sel = 1'b0; tick(1);
        chk("R4 secondary copy", 32'(word_out), 32'(copied));
        ser_bit(1'b0, 2'b01, 1'b1);
        exp_pri = {1'b0, exp_pri[19:1]};
        chk("R4 secondary unaffected", 32'(word_out), 32'(copied));
        freq_sel = 1'b1; tick(1);
        chk("R3 primary after copy", 32'(word_out), 32'(exp_pri));
    endtask

    task automatic t_ee_loads();
        store_rdata = W2; ee_sel = 1'b1; tick(2);
        chk("R5 ee_sel rise load", 32'(word_out), 32'(W2));
        chk("R7 wdata mirrors", 32'(store_wdata), 32'(W2));
        chk_fields("R10 W2", W2);
        store_rdata = W3; ee_load = 1'b1; tick(2);
        chk("R11 hold on ee_load", 32'(word_out), 32'(W2));
        ee_sel = 1'b0; freq_sel = 1'b0; tick(2);
        chk("R11 hold across select change", 32'(word_out), 32'(W2));
        store_rdata = W4; ee_sel = 1'b1; tick(2);
        chk("R5 no load with ee_load high", 32'(store_wdata), 32'(W2));
        ee_load = 1'b0; tick(2);
        chk("R6 ee_load fall load", 32'(word_out), 32'(W4));
        chk("R6 wdata after fall", 32'(store_wdata), 32'(W4));
    endtask

    task automatic t_ee_serial();
        ser_word(W1, 2'b10);
        chk("R7 serial wdata", 32'(store_wdata), 32'(W1));
        chk("R7 output keeps store word", 32'(word_out), 32'(W4));
        freq_sel = 1'b1; ee_sel = 1'b0; tick(1);
        chk("R7 primary untouched", 32'(word_out), 32'(exp_pri));
        store_rdata = W2; ee_sel = 1'b1; tick(2);
        chk("R5 reload clears serial", 32'(word_out), 32'(W2));
    endtask

    task automatic t_readout();
        logic [2:0] bits;
        bits = 3'b101;
        exp_ee = W2;
        readout_en = 1'b1; tick(1);
        chk("R8 dout bit0", 32'(ser_dout), 32'(exp_ee[0]));
        for (int i = 0; i < 3; i++) begin
            ser_bit(bits[i], 2'b00, 1'b0);
            exp_ee = {bits[i], exp_ee[19:1]};
            chk("R8 dout after shift", 32'(ser_dout), 32'(exp_ee[0]));
        end
        chk("R8 wdata after readout", 32'(store_wdata), 32'(exp_ee));
        chk("R7 output during readout", 32'(word_out), 32'(W2));
        if (exp_ee[0] == 1'b0) begin
            ser_bit(1'b1, 2'b00, 1'b0);
            exp_ee = {1'b1, exp_ee[19:1]};
        end
        readout_en = 1'b0; tick(1);
        chk("R9 dout low when disabled", 32'(ser_dout), 0);
        ser_bit(1'b0, 2'b00, 1'b0);
        chk("R9 no shift when disabled", 32'(store_wdata), 32'(exp_ee));
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_primary_load();
        t_live();
        t_no_shift();
        t_secondary();
        t_ee_loads();
        t_ee_serial();
        t_readout();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule